// File: doc/BRIEF.md
# VLIW Bundle NOP Decompressor

This block sits in an instruction decode path and turns a packed stream of 32-bit sub-instructions back into full three-slot, 96-bit VLIW bundles. A compiler removes the no-operation words from each bundle to save code space. In place of each removed word, it leaves two flags on the words it keeps. One flag says that one slot was skipped just before the word. The other says that the word is the last one of its bundle. The decompressor follows a slot pointer across the words of a bundle. It writes each word into the slot of its functional unit and leaves every slot that got no word at the all-zero NOP encoding.

Words arrive on a valid/ready stream. A finished bundle is held on a valid/ready output until the consumer takes it. While it waits, the input is stalled, so no word is lost. A word whose skip flag would move the pointer past the last slot is malformed. It is dropped and it sets a sticky error flag.

Top module: `vliw_unpack`

## Requirements
- R1: After reset the output valid and the error flag are low, the input ready is high, and the first word accepted is placed in slot 0.
- R2: In each input word, bit 31 is the skip flag and bit 30 is the end flag. Slot k of the bundle is carried on out_bundle bits [32k+31:32k], with slot 0 in the lowest bits. A placed word appears with bits 31:30 cleared. The NOP encoding is 32'h0.
- R3: Words with neither flag set fill slots 0, 1 and 2 in turn. The bundle closes and is presented on the cycle after its slot 2 word is accepted.
- R4: A word with the skip flag leaves a NOP in the next slot and lands in the slot after it.
- R5: A word with the end flag closes the bundle and leaves NOP in every later slot. The next accepted word goes to slot 0.
- R6: A word that carries both the skip and the end flag applies the skip first, then closes the bundle after the word is placed.
- R7: A word whose skip would move past slot 2 is dropped and sets the error flag. The partial bundle and the slot pointer stay unchanged, so the next valid word still lands in the slot the pointer held.
- R8: Once set, the error flag stays high until reset.
- R9: While out_valid is high and out_ready is low, in_ready is low and out_bundle holds its value. A word held on the input is accepted only after the bundle has been taken.
- R10: out_valid falls on the cycle after an out_valid/out_ready handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 32 | Compressed sub-instruction with skip and end flags |
| out_valid | output | 1 | Rebuilt bundle is valid |
| out_ready | input | 1 | Consumer takes the bundle |
| out_bundle | output | 96 | Rebuilt three-slot bundle |
| err | output | 1 | Sticky malformed-bundle flag |

## Verification
Two events can fall on the same word. A skip and a bundle close can both happen on one word: the end flag can come together with the skip flag, or a skip can land on slot 2 so that the slot-full close and the end flag coincide. The bench sends such words and compares the whole 96-bit bundle against the slot map worked out from the flags. Backpressure and a pending input word can also overlap. The bench holds a word on the input while the consumer stalls, checks that the held bundle does not change, and then checks that the word shows up exactly once, in slot 0 of the next bundle.

// File: rtl/vup_pkg.sv
package vup_pkg;
  localparam int unsigned SLOT_CNT = 3;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SKIP_POS = 31;
  localparam int unsigned END_POS  = 30;
  localparam int unsigned BUNDLE_W = SLOT_CNT * WORD_W;
  localparam int unsigned PTR_W    = $clog2(SLOT_CNT + 1);
endpackage

// File: rtl/vup_slot_ctrl.sv
module vup_slot_ctrl #(
  parameter int unsigned SLOTS = vup_pkg::SLOT_CNT,
  parameter int unsigned PW    = vup_pkg::PTR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          skip,
  input  logic          endf,
  output logic [PW-1:0] pos,
  output logic          place,
  output logic          close,
  output logic          drop,
  output logic          err
);
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

  logic [PW-1:0] ptr_q, ptr_d;
  logic          err_q, err_d;
  logic          ptr_en;

  always_comb begin
    pos    = ptr_q + PW'(skip);
    place  = take && (pos <= LAST);
    drop   = take && (pos > LAST);
    close  = place && (endf || (pos == LAST));
    ptr_en = place;
    if (close) ptr_d = '0;
    else       ptr_d = pos + PW'(1);
    err_d  = err_q | drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      if (drop)   err_q <= err_d;
    end
  end

  assign err = err_q;

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R7
  drop_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (ptr_q == $past(ptr_q)) && err_q);
  // R5
  close_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> ptr_q == '0);
endmodule

// File: rtl/vup_slot_bank.sv
module vup_slot_bank #(
  parameter int unsigned SLOTS = vup_pkg::SLOT_CNT,
  parameter int unsigned WW    = vup_pkg::WORD_W,
  parameter int unsigned PW    = vup_pkg::PTR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                place,
  input  logic                close,
  input  logic [PW-1:0]       pos,
  input  logic [WW-1:0]       wdata,
  output logic [SLOTS*WW-1:0] merged
);
  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [WW-1:0] slot_q, slot_d;
    logic          hit, slot_en;

    always_comb begin
      hit     = place && (pos == PW'(k));
      slot_en = hit || close;
      if (close)    slot_d = '0;
      else          slot_d = wdata;
      merged[k*WW +: WW] = hit ? wdata : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_en) slot_q <= slot_d;
    end

    // R5
    slot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      close |=> slot_q == '0);
  end
endmodule

// File: rtl/vup_out_reg.sv
module vup_out_reg #(
  parameter int unsigned BW = vup_pkg::BUNDLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [BW-1:0] data,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [BW-1:0] out_data
);
  logic          valid_q, valid_d;
  logic [BW-1:0] data_q;

  always_comb begin
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load) data_q <= data;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !out_ready |=> valid_q && $stable(data_q));
  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid_q);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && out_ready && !load |=> !valid_q);
endmodule

// File: rtl/vliw_unpack.sv
module vliw_unpack #(
  parameter int unsigned SLOTS    = vup_pkg::SLOT_CNT,
  parameter int unsigned WW       = vup_pkg::WORD_W,
  parameter int unsigned SKIP_POS = vup_pkg::SKIP_POS,
  parameter int unsigned END_POS  = vup_pkg::END_POS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [WW-1:0]       in_word,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SLOTS*WW-1:0] out_bundle,
  output logic                err
);
  localparam int unsigned   BW   = SLOTS * WW;
  localparam int unsigned   PW   = $clog2(SLOTS + 1);
  localparam logic [WW-1:0] FLAGS = (WW'(1) << SKIP_POS) | (WW'(1) << END_POS);

  logic          rst_meta, rst_s;
  logic          take, place, close, drop;
  logic [PW-1:0] pos;
  logic [WW-1:0] payload;
  logic [BW-1:0] merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  always_comb begin
    in_ready = rst_s && !out_valid;
    take     = in_valid && in_ready;
    payload  = in_word & ~FLAGS;
  end

  vup_slot_ctrl #(.SLOTS(SLOTS), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .take(take),
    .skip(in_word[SKIP_POS]), .endf(in_word[END_POS]),
    .pos(pos), .place(place), .close(close), .drop(drop), .err(err)
  );

  vup_slot_bank #(.SLOTS(SLOTS), .WW(WW), .PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_s), .place(place), .close(close),
    .pos(pos), .wdata(payload), .merged(merged)
  );

  vup_out_reg #(.BW(BW)) u_out (
    .clk(clk), .rst_n(rst_s), .load(close), .data(merged),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_bundle)
  );

  // R9
  stall_input_chk: assert property (@(posedge clk) disable iff (!rst_s)
    out_valid |-> !in_ready);
  // R7
  drop_no_bundle_chk: assert property (@(posedge clk) disable iff (!rst_s)
    drop && !out_valid |=> !out_valid && err);
endmodule

// File: tb/sim_vliw_unpack.sv
`timescale 1ns/1ps
module sim_vliw_unpack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [95:0] out_bundle;
  logic        err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vliw_unpack u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_bundle(out_bundle), .err(err)
  );

  function automatic logic [31:0] mk(input bit s, input bit e, input logic [29:0] p);
    return {s, e, p};
  endfunction

  function automatic logic [31:0] pl(input logic [29:0] p);
    return {2'b00, p};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_word = w;
    @(posedge clk); #1;
    in_valid = 1'b0; in_word = '0;
  endtask

  task automatic drain(input logic [95:0] exp, input string req);
    chk(out_valid === 1'b1, req, {95'd0, out_valid}, 96'd1);
    chk(out_bundle === exp, req, out_bundle, exp);
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1; out_ready = 1'b0;
    chk(out_valid === 1'b0, "R10", {95'd0, out_valid}, 96'd0);
    chk(in_ready === 1'b1, "R10", {95'd0, in_ready}, 96'd1);
  endtask

  task automatic t_reset();
    do_reset();
    chk(out_valid === 1'b0, "R1", {95'd0, out_valid}, 96'd0);
    chk(err === 1'b0, "R1", {95'd0, err}, 96'd0);
    chk(in_ready === 1'b1, "R1", {95'd0, in_ready}, 96'd1);
  endtask

  task automatic t_full();
    push(mk(0, 0, 30'h0AAA_0001));
    push(mk(0, 0, 30'h0BBB_0002));
    chk(out_valid === 1'b0, "R3", {95'd0, out_valid}, 96'd0);
    push(mk(0, 0, 30'h3CCC_0003));
    drain({pl(30'h3CCC_0003), pl(30'h0BBB_0002), pl(30'h0AAA_0001)}, "R3 R2");
  endtask

  task automatic t_skip();
    push(mk(0, 0, 30'h11));
    push(mk(1, 0, 30'h22));
    drain({pl(30'h22), 32'h0, pl(30'h11)}, "R4");
    push(mk(1, 0, 30'h33));
    push(mk(0, 1, 30'h44));
    drain({pl(30'h44), pl(30'h33), 32'h0}, "R4");
  endtask

  task automatic t_end();
    push(mk(0, 1, 30'h55));
    drain({32'h0, 32'h0, pl(30'h55)}, "R5");
    push(mk(0, 0, 30'h66));
    push(mk(0, 1, 30'h77));
    drain({32'h0, pl(30'h77), pl(30'h66)}, "R5");
  endtask

  task automatic t_skip_end();
    push(mk(1, 1, 30'h88));
    drain({32'h0, pl(30'h88), 32'h0}, "R6");
    push(mk(0, 0, 30'h99));
    push(mk(1, 1, 30'hAA));
    drain({pl(30'hAA), 32'h0, pl(30'h99)}, "R6");
  endtask

  task automatic t_error();
    push(mk(0, 0, 30'h101));
    push(mk(0, 0, 30'h102));
    push(mk(1, 0, 30'h103));
    chk(err === 1'b1, "R7", {95'd0, err}, 96'd1);
    chk(out_valid === 1'b0, "R7", {95'd0, out_valid}, 96'd0);
    push(mk(0, 0, 30'h104));
    drain({pl(30'h104), pl(30'h102), pl(30'h101)}, "R7");
    push(mk(1, 0, 30'h105));
    push(mk(1, 0, 30'h106));
    push(mk(0, 1, 30'h107));
    drain({pl(30'h107), pl(30'h105), 32'h0}, "R7");
    chk(err === 1'b1, "R8", {95'd0, err}, 96'd1);
    do_reset();
    chk(err === 1'b0, "R8", {95'd0, err}, 96'd0);
  endtask

  task automatic t_backpressure();
    logic [95:0] held;
    push(mk(0, 0, 30'h201));
    push(mk(0, 1, 30'h202));
    held = out_bundle;
    @(negedge clk);
    in_valid = 1'b1; in_word = mk(0, 1, 30'h203);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R9", {95'd0, in_ready}, 96'd0);
      chk(out_bundle === held, "R9", out_bundle, held);
    end
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R10", {95'd0, out_valid}, 96'd0);
    @(posedge clk); #1;
    in_valid = 1'b0; in_word = '0;
    drain({32'h0, 32'h0, pl(30'h203)}, "R9");
    chk(out_valid === 1'b0, "R9", {95'd0, out_valid}, 96'd0);
  endtask

  initial begin
    t_reset();
    t_full();
    t_skip();
    t_end();
    t_skip_end();
    t_error();
    t_backpressure();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule